// File: doc/BRIEF.md
# Tagged Caption Byte Queue

This block buffers decoded caption bytes between the line slicer, which writes them, and a host register read port. Every stored entry is ten bits wide. It holds the eight-bit character together with two tag bits. One tag marks whether the byte is the first or the second of its pair. The other marks whether the byte came from a plain caption line or from an extended-data line. The host pops one entry per single-cycle read strobe. The popped entry appears on a registered read port on the following cycle.

Alongside the storage the block keeps several status outputs. A not-empty flag reports stored data. An overflow flag reports a full queue. A fill-level valid flag has hysteresis. An open-drain-style request output pulls low only when its own enable is set. Once the queue is full, it does not drop new bytes. Instead each new write replaces the newest entry, so the oldest data stays in order. A synchronous flush input empties the queue in a single cycle. The writer and the reader run on one clock.

Top module: `caption_fifo`

## Requirements
- R1: Each entry read out on `rd_data` keeps the bit layout it was written with. Bits 7:0 hold the character, bit 8 holds the second-of-pair tag (1 = second byte), and bit 9 holds the extended-data tag (1 = extended data). The popped entry appears on `rd_data` on the clock edge after the cycle in which `rd_en` is sampled.
- R2: The queue holds at most 17 entries. After any sequence of writes, at most 17 reads return stored data.
- R3: `not_empty` is 0 while no entry is stored. It is 1 after the clock edge that stores the first entry.
- R4: `valid_flag` becomes 1 once more than 8 entries are stored. While `pin_en` is 1, `valid_pin_low` follows `valid_flag`.
- R5: While `pin_en` is 0, `valid_pin_low` stays 0 (released) at every fill level.
- R6: `overflow` becomes 1 when 17 entries are stored. A write to a full queue, with no read in the same cycle, replaces only the most recently stored entry and leaves the count at 17.
- R7: `overflow` returns to 0 once reads bring the count below 16. At a count of 16 it keeps its previous value.
- R8: Entries are read out in the order they were written. For a caption pair, the first byte is written and read before the second byte.
- R9: `valid_flag` returns to 0 only when the count drops below 7. At counts 7 and 8 it keeps its previous value.
- R10: A read strobe on an empty queue leaves `rd_data` unchanged and the queue empty.
- R11: A cycle with `flush` high empties the queue and clears `overflow` and `valid_flag` on the next edge. Any read or write in that cycle is ignored.
- R12: A read and a write in the same cycle on a non-empty queue leave the count unchanged. This includes a full queue, where the write then stores normally instead of replacing an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by writer and reader |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Synchronous empty of the queue and its flags |
| wr_en | input | 1 | Write strobe from the slicer |
| wr_byte | input | 8 | Character to store |
| wr_hi | input | 1 | Second-of-pair tag for the written byte |
| wr_ext | input | 1 | Extended-data tag for the written byte |
| rd_en | input | 1 | Single-cycle read strobe from the host |
| rd_data | output | 10 | Last popped entry: {ext, hi, byte} |
| not_empty | output | 1 | High while at least one entry is stored |
| overflow | output | 1 | Full indication with clear-below-16 rule |
| valid_flag | output | 1 | Fill-level indication with 7/8 hysteresis |
| pin_en | input | 1 | Enable for the open-drain request output |
| valid_pin_low | output | 1 | 1 = pull the request line low, 0 = released |

## Verification
On every cycle, the assertions tie the stored count to the flags. They check that the count never passes 17 and that a count above 8 always shows `valid_flag`. They also check that a count below 7 never shows it, that a full queue always shows `overflow`, and that a count below 16 never shows it. Further assertions cover flush, paired read-write and empty reads. The bench's scenarios are the only way to show data integrity: the order of entries, their tag layout, and which entry a full-queue write replaces. They also show that the hysteresis bands hold their previous state, and that the request pin stays released whenever its enable is low. The bench does this by sweeping every fill level from 0 to 17 and draining each one.

// File: rtl/caption_fifo_pkg.sv
package caption_fifo_pkg;

  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned ENTRY_W = CHAR_W + 2;

  typedef struct packed {
    logic              ext;
    logic              hi;
    logic [CHAR_W-1:0] chr;
  } entry_t;

endpackage

// File: rtl/caption_fifo_ctrl.sv
module caption_fifo_ctrl #(
  parameter int unsigned DEPTH = 17,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_go,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_go,
  output logic [PTR_W-1:0] rd_addr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;
  logic             wr_append;
  logic [PTR_W-1:0] newest_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - PTR_W'(1);
  endfunction

  always_comb begin
    full       = (cnt_q == FULL_CNT);
    rd_go      = rd_req && (cnt_q != '0) && !flush;
    wr_go      = wr_req && !flush;
    wr_append  = wr_go && (!full || rd_go);
    newest_ptr = ptr_dec(wr_ptr_q);
    wr_addr    = wr_append ? wr_ptr_q : newest_ptr;
    rd_addr    = rd_ptr_q;
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (wr_append) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (rd_go)     rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({wr_append, rd_go})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign count      = cnt_q;
  assign count_next = cnt_d;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT)
    else $error("count above capacity");

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0))
    else $error("flush did not empty queue");

  p_pair_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_req && !flush && cnt_q != '0) |=> (cnt_q == $past(cnt_q)))
    else $error("paired access changed count");

  p_ovwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !rd_req && !flush && full) |=> (cnt_q == FULL_CNT && $stable(rd_ptr_q)))
    else $error("full write changed count");

endmodule

// File: rtl/caption_fifo_store.sv
module caption_fifo_store
  import caption_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 17,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic [PTR_W-1:0] wr_addr,
  input  entry_t           wr_entry,
  input  logic             rd_go,
  input  logic [PTR_W-1:0] rd_addr,
  output entry_t           rd_entry
);

  entry_t slot_q [DEPTH];
  entry_t rd_q, rd_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_go && (wr_addr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wr_entry;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_go) rd_d = slot_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_entry = rd_q;

endmodule

// File: rtl/caption_fifo_flags.sv
module caption_fifo_flags #(
  parameter int unsigned DEPTH         = 17,
  parameter int unsigned VALID_ABOVE   = 8,
  parameter int unsigned VALID_BELOW   = 7,
  parameter int unsigned OVF_BELOW     = 16,
  parameter int unsigned CNT_W         = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_next,
  output logic             ovf,
  output logic             valid
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] V_SET    = CNT_W'(VALID_ABOVE);
  localparam logic [CNT_W-1:0] V_CLR    = CNT_W'(VALID_BELOW);
  localparam logic [CNT_W-1:0] O_CLR    = CNT_W'(OVF_BELOW);

  logic ovf_q, ovf_d;
  logic val_q, val_d;

  always_comb begin
    ovf_d = ovf_q;
    if (count_next == FULL_CNT)  ovf_d = 1'b1;
    else if (count_next < O_CLR) ovf_d = 1'b0;

    val_d = val_q;
    if (count_next > V_SET)      val_d = 1'b1;
    else if (count_next < V_CLR) val_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      val_q <= val_d;
    end
  end

  assign ovf   = ovf_q;
  assign valid = val_q;

  p_valid_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count > V_SET) |-> val_q)
    else $error("valid low above threshold");

  p_valid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count < V_CLR) |-> !val_q)
    else $error("valid high below threshold");

  p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> ovf_q)
    else $error("overflow low when full");

  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count < O_CLR) |-> !ovf_q)
    else $error("overflow high below limit");

endmodule

// File: rtl/caption_fifo.sv
module caption_fifo
  import caption_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 17,
  parameter int unsigned VALID_ABOVE = 8,
  parameter int unsigned VALID_BELOW = 7,
  parameter int unsigned OVF_BELOW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [CHAR_W-1:0]  wr_byte,
  input  logic               wr_hi,
  input  logic               wr_ext,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               not_empty,
  output logic               overflow,
  output logic               valid_flag,
  input  logic               pin_en,
  output logic               valid_pin_low
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic             wr_go, rd_go;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0] count, count_next;
  entry_t           wr_entry, rd_entry;
  logic             ovf, valid;

  assign wr_entry = '{ext: wr_ext, hi: wr_hi, chr: wr_byte};

  caption_fifo_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_req     (wr_en),
    .rd_req     (rd_en),
    .wr_go      (wr_go),
    .wr_addr    (wr_addr),
    .rd_go      (rd_go),
    .rd_addr    (rd_addr),
    .count      (count),
    .count_next (count_next)
  );

  caption_fifo_store #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_go),
    .wr_addr  (wr_addr),
    .wr_entry (wr_entry),
    .rd_go    (rd_go),
    .rd_addr  (rd_addr),
    .rd_entry (rd_entry)
  );

  caption_fifo_flags #(
    .DEPTH       (DEPTH),
    .VALID_ABOVE (VALID_ABOVE),
    .VALID_BELOW (VALID_BELOW),
    .OVF_BELOW   (OVF_BELOW),
    .CNT_W       (CNT_W)
  ) i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (count),
    .count_next (count_next),
    .ovf        (ovf),
    .valid      (valid)
  );

  assign rd_data       = rd_entry;
  assign not_empty     = (count != '0);
  assign overflow      = ovf;
  assign valid_flag    = valid;
  assign valid_pin_low = valid & pin_en;

  p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> not_empty)
    else $error("write left queue empty");

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !flush && !not_empty) |=> ($stable(rd_data) && !not_empty))
    else $error("empty read disturbed state");

  p_flush_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!overflow && !valid_flag && !not_empty))
    else $error("flush left flags set");

endmodule

// File: tb/test_caption_fifo.sv
module test_caption_fifo;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       flush, wr_en, wr_hi, wr_ext, rd_en, pin_en;
  logic [7:0] wr_byte;
  logic [9:0] rd_data;
  logic       not_empty, overflow, valid_flag, valid_pin_low;

  int n_cmp = 0;
  int n_bad = 0;

  logic [9:0] q [0:16];
  int         qcnt = 0;
  bit         m_ovf = 0, m_val = 0;
  logic [9:0] m_rd = '0;

  always #5 clk = ~clk;

  caption_fifo i_caption_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .wr_en         (wr_en),
    .wr_byte       (wr_byte),
    .wr_hi         (wr_hi),
    .wr_ext        (wr_ext),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .not_empty     (not_empty),
    .overflow      (overflow),
    .valid_flag    (valid_flag),
    .pin_en        (pin_en),
    .valid_pin_low (valid_pin_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 not_empty", 32'(not_empty), 32'(qcnt != 0));
    chk("R6 R7 overflow", 32'(overflow), 32'(m_ovf));
    chk("R4 R9 valid_flag", 32'(valid_flag), 32'(m_val));
    chk("R4 R5 valid_pin_low", 32'(valid_pin_low), 32'(m_val && pin_en));
    chk("R1 R8 R10 rd_data", 32'(rd_data), 32'(m_rd));
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input bit w, input bit r, input bit f, input logic [9:0] d);
    wr_en = w; rd_en = r; flush = f;
    {wr_ext, wr_hi, wr_byte} = d;
    @(posedge clk);
    if (f) begin
      qcnt = 0;
    end else begin
      if (r && qcnt > 0) begin
        m_rd = q[0];
        for (int i = 0; i < 16; i++) q[i] = q[i+1];
        qcnt--;
      end
      if (w) begin
        if (qcnt < 17) begin q[qcnt] = d; qcnt++; end
        else q[16] = d;
      end
    end
    if (qcnt == 17)     m_ovf = 1;
    else if (qcnt < 16) m_ovf = 0;
    if (qcnt > 8)       m_val = 1;
    else if (qcnt < 7)  m_val = 0;
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0;
    check_all();
  endtask

  function automatic logic [9:0] pat(input int i);
    return 10'((i * 37 + 5) ^ ((i & 3) << 8));
  endfunction

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; wr_en = 0; rd_en = 0; pin_en = 1;
    wr_byte = 0; wr_hi = 0; wr_ext = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();  // reset state

    // R2 R6: fill past capacity; writes 18..20 replace the newest entry
    for (int i = 0; i < 20; i++) step(1, 0, 0, pat(i));
    // R7 R8 R9: drain to empty plus extra, checking order and hysteresis
    for (int i = 0; i < 19; i++) step(0, 1, 0, '0);
    chk("R2 drained count", 32'(not_empty), 32'd0);
    // R10: empty reads
    step(0, 1, 0, '0);
    step(0, 1, 0, '0);

    // R8: caption pair, first byte then second byte, both tag kinds
    step(1, 0, 0, {1'b0, 1'b0, 8'h41});
    step(1, 0, 0, {1'b0, 1'b1, 8'h42});
    step(1, 0, 0, {1'b1, 1'b0, 8'hC3});
    step(1, 0, 0, {1'b1, 1'b1, 8'h7F});
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0);

    // R5: pin released at every level with enable low
    pin_en = 0;
    for (int i = 0; i < 17; i++) step(1, 0, 0, pat(100 + i));
    // R12: paired access at full, then at mid level
    step(1, 1, 0, pat(200));
    step(1, 1, 0, pat(201));
    pin_en = 1;
    for (int i = 0; i < 9; i++) step(0, 1, 0, '0);
    step(1, 1, 0, pat(202));
    step(1, 1, 0, pat(203));
    // R11: flush with read and write asserted together
    step(1, 1, 1, pat(204));
    step(0, 1, 0, '0);

    // near-exhaustive sweep over every fill level, toggling pin enable
    for (int k = 0; k <= 17; k++) begin
      pin_en = k[0];
      step(0, 0, 1, '0);
      for (int i = 0; i < k; i++) step(1, 0, 0, pat(300 + k * 20 + i));
      step(1, 0, 0, pat(700 + k));   // extra write: R6 replace when full
      for (int i = 0; i <= k + 1; i++) step(0, 1, 0, '0);
    end

    // R11: flush from full with overflow set
    pin_en = 1;
    for (int i = 0; i < 18; i++) step(1, 0, 0, pat(900 + i));
    step(0, 0, 1, '0);
    step(1, 0, 0, pat(950));
    step(0, 1, 0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule